// File: doc/BRIEF.md
# MSI-X Capability Control Registers

This block holds the MSI-X capability structure that a PCI function places in its configuration space. Software reaches it through a dword-wide configuration port with per-byte enables. A read returns one of the three capability dwords: the header with the message-control word, the vector-table locator and the pending-bit-array locator. All layout values come from build-time parameters: the number of vectors, the index of the BAR that carries the MSI-X page, and the size that BAR had before MSI-X space was added. From the original BAR size the block derives the enlarged BAR size and the two locator offsets.

Software can change only two bits: the MSI-X enable bit and the function-mask bit. Both sit in the upper byte of the message-control word. A write whose byte enables include that control byte leads to two results one cycle after the new value is committed. The legacy INTx lines get a deassert pulse when MSI-X is on. The downstream interrupt engine gets a scan request when MSI-X is on and not function-masked. An illegal parameter set (a vector count or BAR size out of range) makes the whole capability read as zero and ignore writes.

Top module: `msixcap_regs`

## Requirements
- R1: After reset, enable and function-mask are 0, `scan_req` and `intx_clr` are low, and dword 0 reads capability ID 0x11 in bits [7:0] with next-pointer 0 in bits [15:8].
- R2: Dword 0 bits [26:16] hold NUM_VECTORS-1. Bits [29:27] read 0. Bit 31 is enable and bit 30 is function-mask.
- R3: `bar_total_size` is 0x1000 when the original size is 0, 0x2000 when it is below 0x1000, and twice the original size otherwise.
- R4: Dword 1 reads B | BAR_INDEX. B is 0 for an original size of 0, 0x1000 for a size below 0x1000, and the original size otherwise.
- R5: Dword 2 reads (B + 0x800) | BAR_INDEX. Dword 3 (`cfg_dw_sel`=3) reads 0.
- R6: Only dword-0 bits 31 and 30 are writable. Writes to every other bit, and to dwords 1 to 3, leave the read data unchanged.
- R7: A write with `cfg_be[3]`=0, or with `cfg_dw_sel`≠0, changes nothing and produces no `scan_req` or `intx_clr` pulse.
- R8: A control-byte write that leaves enable=1 drives every `intx_clr` bit high for exactly one cycle, one cycle after the new value first appears on `msix_en`.
- R9: A control-byte write that leaves enable=1 and function-mask=0 drives `scan_req` high for exactly one cycle, in the same cycle as the R8 pulse. Otherwise no scan pulse appears.
- R10: If NUM_VECTORS is outside 1..2048 or the original BAR size exceeds 0x80000000, then `cfg_ok`=0, `bar_total_size`=0, every read returns 0 and writes have no effect.
- R11: `cfg_rdata` is registered. It shows the selected dword in the cycle after `cfg_rd_en`=1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_dw_sel | input | 2 | Dword index within the capability |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| msix_en | output | 1 | Current MSI-X enable bit |
| func_mask | output | 1 | Current function-mask bit |
| scan_req | output | 1 | One-cycle request to re-scan all vectors |
| intx_clr | output | NUM_INTX | One-cycle deassert pulse for each legacy INTx line |
| bar_total_size | output | 33 | Enlarged BAR size in bytes |
| cfg_ok | output | 1 | Parameter set is legal |

## Verification
A table of control-byte writes walks the enable/mask pair through all four combinations. Each write uses a different byte-enable pattern: control byte alone, all bytes, the upper half, and the lower three bytes only. These separate a real control hit from a near miss, and a disable from a mask. The table also separates a pulse that depends on the committed value from one that depends on the prior value. Instances built from zero, sub-page, mid-size and maximum original BAR sizes show the four growth branches apart. Two illegal builds confirm that out-of-range vector counts and BAR sizes blank the capability.

// File: rtl/msixcap_pkg.sv
package msixcap_pkg;

    localparam int unsigned MAX_VECTORS = 2048;
    localparam int unsigned PAGE_BYTES  = 4096;
    localparam int unsigned PBA_SHIFT   = PAGE_BYTES / 2;
    localparam logic [7:0]  CAP_ID      = 8'h11;

    typedef struct packed {
        logic en;
        logic fmask;
        logic touched;
        logic scan;
        logic intx;
    } ctrl_state_t;

    function automatic logic params_legal(input int nvec, input longint unsigned orig);
        return (nvec >= 1) && (nvec <= int'(MAX_VECTORS)) && (orig <= 64'h8000_0000);
    endfunction

    function automatic logic [32:0] grown_size(input longint unsigned orig);
        longint unsigned r;
        if (orig == 0)
            r = 64'(PAGE_BYTES);
        else if (orig < 64'(PAGE_BYTES))
            r = 64'(2 * PAGE_BYTES);
        else
            r = orig * 2;
        return r[32:0];
    endfunction

    function automatic logic [31:0] table_base(input longint unsigned orig);
        longint unsigned r;
        if (orig == 0)
            r = 0;
        else if (orig < 64'(PAGE_BYTES))
            r = 64'(PAGE_BYTES);
        else
            r = orig;
        return r[31:0];
    endfunction

endpackage

// File: rtl/msixcap_layout.sv
module msixcap_layout
    import msixcap_pkg::*;
#(
    parameter int              NUM_VECTORS    = 8,
    parameter int              BAR_INDEX      = 2,
    parameter longint unsigned ORIG_BAR_BYTES = 64'h2000
) (
    output logic [31:0] hdr_static,
    output logic [31:0] table_dw,
    output logic [31:0] pba_dw,
    output logic [32:0] bar_size,
    output logic        legal
);
    localparam logic LEGAL = params_legal(NUM_VECTORS, ORIG_BAR_BYTES);
    localparam logic [2:0] BIR = 3'(BAR_INDEX);

    generate
        if (LEGAL) begin : g_legal
            localparam logic [10:0] QSIZE = 11'(NUM_VECTORS - 1);
            localparam logic [31:0] TBASE = table_base(ORIG_BAR_BYTES);
            assign hdr_static = {5'b0, QSIZE, 8'h00, CAP_ID};
            assign table_dw   = TBASE | {29'b0, BIR};
            assign pba_dw     = (TBASE + 32'(PBA_SHIFT)) | {29'b0, BIR};
            assign bar_size   = grown_size(ORIG_BAR_BYTES);
            assign legal      = 1'b1;
        end else begin : g_illegal
            assign hdr_static = '0;
            assign table_dw   = '0;
            assign pba_dw     = '0;
            assign bar_size   = '0;
            assign legal      = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/msixcap_ctrl.sv
module msixcap_ctrl
    import msixcap_pkg::*;
#(
    parameter int NUM_INTX = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                legal,
    input  logic                wr_en,
    input  logic [1:0]          dw_sel,
    input  logic                ctrl_be,
    input  logic [1:0]          wbits,
    output logic                en,
    output logic                fmask,
    output logic                scan,
    output logic [NUM_INTX-1:0] intx
);
    ctrl_state_t st_d, st_q;
    logic hit;

    assign hit = legal && wr_en && (dw_sel == 2'd0) && ctrl_be;

    always_comb begin
        st_d         = st_q;
        st_d.touched = hit;
        st_d.scan    = 1'b0;
        st_d.intx    = 1'b0;
        if (st_q.touched) begin
            st_d.scan = st_q.en && !st_q.fmask;
            st_d.intx = st_q.en;
        end
        if (hit) begin
            st_d.en    = wbits[1];
            st_d.fmask = wbits[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign en    = st_q.en;
    assign fmask = st_q.fmask;
    assign scan  = st_q.scan;
    assign intx  = {NUM_INTX{st_q.intx}};
endmodule

// File: rtl/msixcap_rdmux.sv
module msixcap_rdmux (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic [1:0]  dw_sel,
    input  logic [31:0] hdr_static,
    input  logic [31:0] table_dw,
    input  logic [31:0] pba_dw,
    input  logic        en,
    input  logic        fmask,
    output logic [31:0] rdata
);
    logic [31:0] rdata_d, rdata_q, sel_dw;

    always_comb begin
        case (dw_sel)
            2'd0:    sel_dw = hdr_static | {en, fmask, 30'b0};
            2'd1:    sel_dw = table_dw;
            2'd2:    sel_dw = pba_dw;
            default: sel_dw = '0;
        endcase
        rdata_d = rd_en ? sel_dw : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else
            rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/msixcap_regs.sv
module msixcap_regs
    import msixcap_pkg::*;
#(
    parameter int              NUM_VECTORS    = 8,
    parameter int              BAR_INDEX      = 2,
    parameter longint unsigned ORIG_BAR_BYTES = 64'h2000,
    parameter int              NUM_INTX       = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic                cfg_rd_en,
    input  logic [1:0]          cfg_dw_sel,
    input  logic [3:0]          cfg_be,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    output logic                msix_en,
    output logic                func_mask,
    output logic                scan_req,
    output logic [NUM_INTX-1:0] intx_clr,
    output logic [32:0]         bar_total_size,
    output logic                cfg_ok
);
    logic [31:0] hdr_static, table_dw, pba_dw;
    logic        wdata_unused;

    assign wdata_unused = ^{cfg_wdata[29:0], cfg_be[2:0]};

    msixcap_layout #(
        .NUM_VECTORS   (NUM_VECTORS),
        .BAR_INDEX     (BAR_INDEX),
        .ORIG_BAR_BYTES(ORIG_BAR_BYTES)
    ) u_layout (
        .hdr_static(hdr_static),
        .table_dw  (table_dw),
        .pba_dw    (pba_dw),
        .bar_size  (bar_total_size),
        .legal     (cfg_ok)
    );

    msixcap_ctrl #(.NUM_INTX(NUM_INTX)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .legal  (cfg_ok),
        .wr_en  (cfg_wr_en),
        .dw_sel (cfg_dw_sel),
        .ctrl_be(cfg_be[3]),
        .wbits  (cfg_wdata[31:30]),
        .en     (msix_en),
        .fmask  (func_mask),
        .scan   (scan_req),
        .intx   (intx_clr)
    );

    msixcap_rdmux u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (cfg_rd_en),
        .dw_sel    (cfg_dw_sel),
        .hdr_static(hdr_static),
        .table_dw  (table_dw),
        .pba_dw    (pba_dw),
        .en        (msix_en),
        .fmask     (func_mask),
        .rdata     (cfg_rdata)
    );
endmodule

// File: rtl/msixcap_chk.sv
module msixcap_chk #(
    parameter int NUM_INTX = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_wr_en,
    input logic                cfg_rd_en,
    input logic [1:0]          cfg_dw_sel,
    input logic [3:0]          cfg_be,
    input logic [31:0]         cfg_rdata,
    input logic                msix_en,
    input logic                func_mask,
    input logic                scan_req,
    input logic [NUM_INTX-1:0] intx_clr,
    input logic                cfg_ok
);
    AST_SCAN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |=> !scan_req); // R9
    AST_SCAN_COND: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |-> $past(msix_en && !func_mask)); // R9
    AST_SCAN_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |-> $past(cfg_wr_en && cfg_dw_sel == 2'd0 && cfg_be[3], 2)); // R9
    AST_INTX_WITH_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |-> (&intx_clr)); // R8
    AST_INTX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        intx_clr[0] |=> !intx_clr[0]); // R8
    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr_en && cfg_dw_sel == 2'd0 && cfg_be[3]) |=> $stable({msix_en, func_mask})); // R7
    AST_BAD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |-> (cfg_rdata == 32'h0 && !msix_en && !scan_req)); // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_en |=> $stable(cfg_rdata)); // R11
endmodule

bind msixcap_regs msixcap_chk #(.NUM_INTX(NUM_INTX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_rd_en (cfg_rd_en),
    .cfg_dw_sel(cfg_dw_sel),
    .cfg_be    (cfg_be),
    .cfg_rdata (cfg_rdata),
    .msix_en   (msix_en),
    .func_mask (func_mask),
    .scan_req  (scan_req),
    .intx_clr  (intx_clr),
    .cfg_ok    (cfg_ok)
);

// File: tb/sim_msixcap_regs.sv
module sim_msixcap_regs;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [3:0]  be = 4'd0;
    logic [31:0] wd = 32'd0;

    logic [31:0] rdat [6];
    logic        en_o [6];
    logic        mk_o [6];
    logic        sc_o [6];
    logic [3:0]  ix_o [6];
    logic [32:0] bs_o [6];
    logic        ok_o [6];

    int checks = 0;
    int fails  = 0;

    msixcap_regs #(.NUM_VECTORS(8), .BAR_INDEX(2), .ORIG_BAR_BYTES(64'h2000)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr), .cfg_rd_en(rd), .cfg_dw_sel(sel),
        .cfg_be(be), .cfg_wdata(wd), .cfg_rdata(rdat[0]), .msix_en(en_o[0]),
        .func_mask(mk_o[0]), .scan_req(sc_o[0]), .intx_clr(ix_o[0]),
        .bar_total_size(bs_o[0]), .cfg_ok(ok_o[0]));
    msixcap_regs #(.NUM_VECTORS(1), .BAR_INDEX(0), .ORIG_BAR_BYTES(64'h100)) u_small (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr), .cfg_rd_en(rd), .cfg_dw_sel(sel),
        .cfg_be(be), .cfg_wdata(wd), .cfg_rdata(rdat[1]), .msix_en(en_o[1]),
        .func_mask(mk_o[1]), .scan_req(sc_o[1]), .intx_clr(ix_o[1]),
        .bar_total_size(bs_o[1]), .cfg_ok(ok_o[1]));
    msixcap_regs #(.NUM_VECTORS(2048), .BAR_INDEX(5), .ORIG_BAR_BYTES(64'h0)) u_zero (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr), .cfg_rd_en(rd), .cfg_dw_sel(sel),
        .cfg_be(be), .cfg_wdata(wd), .cfg_rdata(rdat[2]), .msix_en(en_o[2]),
        .func_mask(mk_o[2]), .scan_req(sc_o[2]), .intx_clr(ix_o[2]),
        .bar_total_size(bs_o[2]), .cfg_ok(ok_o[2]));
    msixcap_regs #(.NUM_VECTORS(32), .BAR_INDEX(1), .ORIG_BAR_BYTES(64'h8000_0000)) u_big (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr), .cfg_rd_en(rd), .cfg_dw_sel(sel),
        .cfg_be(be), .cfg_wdata(wd), .cfg_rdata(rdat[3]), .msix_en(en_o[3]),
        .func_mask(mk_o[3]), .scan_req(sc_o[3]), .intx_clr(ix_o[3]),
        .bar_total_size(bs_o[3]), .cfg_ok(ok_o[3]));
    msixcap_regs #(.NUM_VECTORS(2049), .BAR_INDEX(1), .ORIG_BAR_BYTES(64'h2000)) u_badn (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr), .cfg_rd_en(rd), .cfg_dw_sel(sel),
        .cfg_be(be), .cfg_wdata(wd), .cfg_rdata(rdat[4]), .msix_en(en_o[4]),
        .func_mask(mk_o[4]), .scan_req(sc_o[4]), .intx_clr(ix_o[4]),
        .bar_total_size(bs_o[4]), .cfg_ok(ok_o[4]));
    msixcap_regs #(.NUM_VECTORS(8), .BAR_INDEX(1), .ORIG_BAR_BYTES(64'h8000_0001)) u_badb (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr), .cfg_rd_en(rd), .cfg_dw_sel(sel),
        .cfg_be(be), .cfg_wdata(wd), .cfg_rdata(rdat[5]), .msix_en(en_o[5]),
        .func_mask(mk_o[5]), .scan_req(sc_o[5]), .intx_clr(ix_o[5]),
        .bar_total_size(bs_o[5]), .cfg_ok(ok_o[5]));

    // vector: [39:36] byte enables, [35:4] write data, [3] en, [2] mask, [1] scan, [0] intx
    localparam logic [39:0] VEC [7] = '{
        {4'b0111, 32'hFFFF_FFFF, 4'b0000},
        {4'b1000, 32'h8000_0000, 4'b1011},
        {4'b1000, 32'hC000_0000, 4'b1101},
        {4'b1111, 32'h4000_0000, 4'b0100},
        {4'b1100, 32'hBFFF_FFFF, 4'b1011},
        {4'b0111, 32'h0000_0000, 4'b1000},
        {4'b1000, 32'h0000_0000, 4'b0000}
    };

    localparam logic [31:0] U0_HDR = 32'h0007_0011;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic s_commit, s_pulse, s_after;
    logic [3:0] i_pulse;

    task automatic do_write(input logic [1:0] s, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; sel = s; be = b; wd = d;
        @(negedge clk);
        wr = 1'b0; be = 4'd0;
        s_commit = sc_o[0];
        @(negedge clk);
        s_pulse = sc_o[0];
        i_pulse = ix_o[0];
        @(negedge clk);
        s_after = sc_o[0];
    endtask

    task automatic do_read(input logic [1:0] s);
        @(negedge clk);
        rd = 1'b1; sel = s;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 en", 64'(en_o[0]), 64'd0);
        check("R1 mask", 64'(mk_o[0]), 64'd0);
        check("R1 scan", 64'(sc_o[0]), 64'd0);
        check("R1 intx", 64'(ix_o[0]), 64'd0);
        do_read(2'd0);
        check("R1 R2 hdr", 64'(rdat[0]), 64'(U0_HDR));

        // R11: read data held while no read strobe
        @(negedge clk); sel = 2'd1;
        @(negedge clk);
        check("R11 hold", 64'(rdat[0]), 64'(U0_HDR));

        // table walk of control writes: R7 R8 R9 R6
        for (int k = 0; k < 7; k++) begin
            logic [39:0] v;
            v = VEC[k];
            do_write(2'd0, v[39:36], v[35:4]);
            check($sformatf("R9 v%0d scan at commit", k), 64'(s_commit), 64'd0);
            check($sformatf("R9 v%0d scan pulse", k), 64'(s_pulse), 64'(v[1]));
            check($sformatf("R8 v%0d intx pulse", k), 64'(i_pulse), 64'({4{v[0]}}));
            check($sformatf("R9 v%0d scan after", k), 64'(s_after), 64'd0);
            check($sformatf("R7 v%0d en", k), 64'(en_o[0]), 64'(v[3]));
            check($sformatf("R7 v%0d mask", k), 64'(mk_o[0]), 64'(v[2]));
            do_read(2'd0);
            check($sformatf("R6 v%0d hdr", k), 64'(rdat[0]), 64'({v[3], v[2], 30'b0} | U0_HDR));
        end

        // R4 R5: locators and size per instance (R3)
        do_read(2'd1);
        check("R4 u0", 64'(rdat[0]), 64'h2002);
        check("R4 small", 64'(rdat[1]), 64'h1000);
        check("R4 zero", 64'(rdat[2]), 64'h0005);
        check("R4 big", 64'(rdat[3]), 64'h8000_0001);
        do_read(2'd2);
        check("R5 u0", 64'(rdat[0]), 64'h2802);
        check("R5 small", 64'(rdat[1]), 64'h1800);
        check("R5 zero", 64'(rdat[2]), 64'h0805);
        check("R5 big", 64'(rdat[3]), 64'h8000_0801);
        do_read(2'd3);
        check("R5 dw3", 64'(rdat[0]), 64'h0);
        check("R3 u0", 64'(bs_o[0]), 64'h4000);
        check("R3 small", 64'(bs_o[1]), 64'h2000);
        check("R3 zero", 64'(bs_o[2]), 64'h1000);
        check("R3 big", 64'(bs_o[3]), 64'h1_0000_0000);
        do_read(2'd0);
        check("R2 small", 64'(rdat[1]), 64'h0000_0011);
        check("R2 zero", 64'(rdat[2]), 64'h07FF_0011);
        check("R2 big", 64'(rdat[3]), 64'h001F_0011);

        // R6 R7: write to locator dword ignored
        do_write(2'd1, 4'b1111, 32'hFFFF_FFFF);
        check("R7 dw1 wr scan", 64'(s_pulse), 64'd0);
        check("R7 dw1 wr en", 64'(en_o[0]), 64'd0);
        do_read(2'd1);
        check("R6 dw1 kept", 64'(rdat[0]), 64'h2002);

        // R10: illegal builds
        do_write(2'd0, 4'b1000, 32'h8000_0000);
        check("R8 enable intx", 64'(i_pulse), 64'hF);
        check("R10 badn ok", 64'(ok_o[4]), 64'd0);
        check("R10 badb ok", 64'(ok_o[5]), 64'd0);
        check("R10 badn bar", 64'(bs_o[4]), 64'd0);
        check("R10 badb en", 64'(en_o[5]), 64'd0);
        check("R10 badn scan", 64'(sc_o[4]), 64'd0);
        do_read(2'd0);
        check("R10 badn rd", 64'(rdat[4]), 64'd0);
        check("R10 badb rd", 64'(rdat[5]), 64'd0);
        check("R10 good rd", 64'(rdat[0]), 64'(32'h8000_0000 | U0_HDR));

        // R1: reset clears writable bits
        do_write(2'd0, 4'b1000, 32'hC000_0000);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 reset en", 64'(en_o[0]), 64'd0);
        check("R1 reset mask", 64'(mk_o[0]), 64'd0);
        do_read(2'd0);
        check("R1 reset hdr", 64'(rdat[0]), 64'(U0_HDR));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule